// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port that a board tester uses to reach a chip's boundary-scan chain. It follows the standard 16-state controller, which is stepped by the mode-select input on each rising edge of the test clock. It holds a 4-bit instruction register and a single-bit bypass stage. It decodes a fixed opcode map into a set of control lines. These lines put the external boundary chain into the serial path, strobe that chain's capture, shift and update phases, hold the core in a soft reset during external pin testing, float the output pins, or clamp them from the chain's update latches.

The boundary cells are not part of this block. The chain is reached through its serial output (`chain_so`) and the three phase strobes. A chain of any length can be attached; the bench attaches a 475-cell model. Serial data in and mode select are sampled on rising test-clock edges. Serial data out is launched on falling edges, together with an enable that the pad uses to drive the pin or leave it floating. An asynchronous active-low port reset returns the controller to its idle reset state.

Top module: `scan_tap`

## Requirements
- R1: Driving `trst_n` low at once puts the controller in Test-Logic-Reset, clears `tdo_oe` and `tdo`, and selects the bypass decode, without waiting for a clock edge. When `trst_n` is low, `chain_sel`, `soft_rst`, `out_from_chain`, `hiz_en` and `clamp_en` are all 0.
- R2: The controller moves through the 16 standard states on rising `tck` edges under `tms`. Five consecutive rising edges with `tms` = 1 reach Test-Logic-Reset from any state.
- R3: In Capture-IR the 4-bit instruction shift stage loads 0001. In Shift-IR the stage moves one bit toward `tdo` per clock, least significant bit first, and takes `tdi` into its most significant bit. The shifted value becomes the active instruction when the controller passes through Update-IR.
- R4: The active instruction decodes as follows:
  - 0000 selects external test.
  - 0001 selects sample/preload.
  - 0100 selects float-pins.
  - 0101 selects clamp.
  - Every other code selects bypass. This covers the pattern 0x1x and all codes with bit 3 set.
  - At most one of `soft_rst`, `hiz_en` and `clamp_en` is high at any time.
- R5: External test raises `chain_sel`, `soft_rst` and `out_from_chain`. Through the data path, the captured chain contents come out on `tdo`, followed by the `tdi` bits delayed by the chain length.
- R6: Sample/preload raises `chain_sel` only. `soft_rst`, `out_from_chain`, `hiz_en` and `clamp_en` stay 0. The data path goes through the chain, as for external test.
- R7: Float-pins raises `hiz_en` only. Clamp raises `clamp_en` and `out_from_chain`. In both cases `chain_sel` is 0 and the data path is the bypass stage.
- R8: With the bypass stage in the path, Capture-DR loads 0. During Shift-DR, a bit driven on `tdi` before a rising edge appears on `tdo` one `tck` cycle after it was presented.
- R9: `chain_capture`, `chain_shift` and `chain_update` are high only while `chain_sel` is high and the controller is in Capture-DR, Shift-DR or Update-DR, respectively. At most one of the three is high at a time.
- R10: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: While the controller is in Test-Logic-Reset, the decode is bypass whatever the instruction register holds. On the first rising edge spent in Test-Logic-Reset, the register itself is set to 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, launched on falling tck |
| tdo_oe | output | 1 | Pad drive enable for tdo; pin floats when 0 |
| chain_so | input | 1 | Serial output of the external boundary chain |
| chain_sel | output | 1 | Boundary chain is in the TDI-TDO path |
| chain_capture | output | 1 | Chain loads its parallel inputs at the next rising tck |
| chain_shift | output | 1 | Chain shifts one place at the next rising tck |
| chain_update | output | 1 | Chain copies its shift stage to its update latches |
| soft_rst | output | 1 | Holds core logic in reset during external test |
| out_from_chain | output | 1 | Output pins are driven from chain update latches |
| hiz_en | output | 1 | All output pins float |
| clamp_en | output | 1 | Output pins held from chain latches with bypass in path |

## Verification
The decoded controls settle on the rising edge that leaves Update-IR. The bench therefore reads them once the controller is in Run-Test-Idle. The strobes follow the state held since the last rising edge, so they are read one step after the transition that enters each data-register state. `tdo` and `tdo_oe` move only on falling edges. After every step, the bench samples one time unit past the falling edge. It predicts the bit at position j of a data shift as the bypass stage's 0 followed by `tdi` delayed by one, or as the captured chain pattern followed by `tdi` delayed by the chain length. One dedicated check reads `tdo` just after a rising edge to show that it holds until the falling edge. Reset is checked between edges, before any clock can act.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    OP_EXTEST, OP_SAMPLE, OP_HIGHZ, OP_CLAMP, OP_BYPASS
  } tap_op_e;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state_q,
  output logic       ir_so,
  output tap_op_e    op
);

  localparam logic [IR_W-1:0] CAPT_PAT = IR_W'(1);
  localparam logic [IR_W-1:0] BYP_CODE = '1;
  localparam logic [IR_W-1:0] C_EXTEST = '0;
  localparam logic [IR_W-1:0] C_SAMPLE = IR_W'(1);
  localparam logic [IR_W-1:0] C_HIGHZ  = IR_W'(4);
  localparam logic [IR_W-1:0] C_CLAMP  = IR_W'(5);

  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= CAPT_PAT;
      ir_q <= BYP_CODE;
    end else begin
      case (state_q)
        ST_CAP_IR: sr_q <= CAPT_PAT;
        ST_SHF_IR: sr_q <= {tdi, sr_q[IR_W-1:1]};
        ST_UPD_IR: ir_q <= sr_q;
        ST_TLR:    ir_q <= BYP_CODE;
        default:   ;
      endcase
    end
  end

  assign ir_so = sr_q[0];

  always_comb begin
    if (state_q == ST_TLR)      op = OP_BYPASS;
    else if (ir_q == C_EXTEST)  op = OP_EXTEST;
    else if (ir_q == C_SAMPLE)  op = OP_SAMPLE;
    else if (ir_q == C_HIGHZ)   op = OP_HIGHZ;
    else if (ir_q == C_CLAMP)   op = OP_CLAMP;
    else                        op = OP_BYPASS;
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int IR_W = 4
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  input  logic chain_so,
  output logic chain_sel,
  output logic chain_capture,
  output logic chain_shift,
  output logic chain_update,
  output logic soft_rst,
  output logic out_from_chain,
  output logic hiz_en,
  output logic clamp_en
);

  tap_state_e state_q;
  tap_op_e    op;
  logic       ir_so;
  logic       byp_q;
  logic       in_shift_ir;
  logic       in_shift_dr;

  scan_tap_fsm u_fsm (
    .tck     (tck),
    .trst_n  (trst_n),
    .tms     (tms),
    .state_q (state_q)
  );

  scan_tap_ir #(.IR_W(IR_W)) u_ir (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .state_q (state_q),
    .ir_so   (ir_so),
    .op      (op)
  );

  assign in_shift_ir = (state_q == ST_SHF_IR);
  assign in_shift_dr = (state_q == ST_SHF_DR);

  // Bypass stage: zero on capture, one-bit shift path otherwise
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                    byp_q <= 1'b0;
    else if (state_q == ST_CAP_DR)  byp_q <= 1'b0;
    else if (in_shift_dr)           byp_q <= tdi;
  end

  assign chain_sel      = (op == OP_EXTEST) || (op == OP_SAMPLE);
  assign soft_rst       = (op == OP_EXTEST);
  assign out_from_chain = (op == OP_EXTEST) || (op == OP_CLAMP);
  assign hiz_en         = (op == OP_HIGHZ);
  assign clamp_en       = (op == OP_CLAMP);

  assign chain_capture  = chain_sel && (state_q == ST_CAP_DR);
  assign chain_shift    = chain_sel && in_shift_dr;
  assign chain_update   = chain_sel && (state_q == ST_UPD_DR);

  // Serial output launched on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift_ir || in_shift_dr;
      if (in_shift_ir)    tdo <= ir_so;
      else if (chain_sel) tdo <= chain_so;
      else                tdo <= byp_q;
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tdi,
  input logic       tdo,
  input logic       tdo_oe,
  input logic       chain_sel,
  input logic       chain_capture,
  input logic       chain_shift,
  input logic       chain_update,
  input logic       soft_rst,
  input logic       out_from_chain,
  input logic       hiz_en,
  input logic       clamp_en,
  input tap_state_e state
);

  a_r4_one_mode: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({soft_rst, hiz_en, clamp_en}));

  a_r5_extest_controls: assert property (@(posedge tck) disable iff (!trst_n)
    soft_rst |-> (chain_sel && out_from_chain));

  a_r7_hiz_off_chain: assert property (@(posedge tck) disable iff (!trst_n)
    (hiz_en || clamp_en) |-> !chain_sel);

  a_r8_bypass_delay: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_SHF_DR && $past(state) == ST_SHF_DR && !chain_sel && !$past(chain_sel))
      |-> (tdo == $past(tdi)));

  a_r9_strobe_needs_sel: assert property (@(posedge tck) disable iff (!trst_n)
    (chain_capture || chain_shift || chain_update) |-> chain_sel);

  a_r9_strobe_onehot: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({chain_capture, chain_shift, chain_update}));

  a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  a_r11_reset_state_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> !(chain_sel || soft_rst || hiz_en || clamp_en || out_from_chain));

endmodule

bind scan_tap scan_tap_chk u_chk (.*, .state(state_q));

// File: tb/scan_tap_test.sv
module scan_tap_test;

  localparam int TCK_P     = 10;
  localparam int CHAIN_LEN = 475;
  localparam int BYP_BITS  = 16;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe, chain_so;
  logic chain_sel, chain_capture, chain_shift, chain_update;
  logic soft_rst, out_from_chain, hiz_en, clamp_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  scan_tap uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .chain_so(chain_so),
    .chain_sel(chain_sel), .chain_capture(chain_capture),
    .chain_shift(chain_shift), .chain_update(chain_update),
    .soft_rst(soft_rst), .out_from_chain(out_from_chain),
    .hiz_en(hiz_en), .clamp_en(clamp_en)
  );

  always #(TCK_P/2) tck = ~tck;

  // Boundary chain model
  function automatic logic cap_bit(int i);
    return ((i % 3) == 0) ^ ((i % 7) == 2);
  endfunction

  function automatic logic pat_bit(int k);
    return ((k * 7 + 3) % 5) < 2;
  endfunction

  logic [CHAIN_LEN-1:0] chain_sr = '0;

  always @(posedge tck) begin
    if (chain_capture) begin
      for (int i = 0; i < CHAIN_LEN; i++) chain_sr[i] <= cap_bit(i);
    end else if (chain_shift) begin
      chain_sr <= {tdi, chain_sr[CHAIN_LEN-1:1]};
    end
  end
  assign chain_so = chain_sr[0];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // {chain_sel, soft_rst, out_from_chain, hiz_en, clamp_en}
  function automatic logic [4:0] exp_ctl(int code);
    case (code)
      0:       return 5'b11100;
      1:       return 5'b10000;
      4:       return 5'b00010;
      5:       return 5'b00101;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [4:0] ctl();
    return {chain_sel, soft_rst, out_from_chain, hiz_en, clamp_en};
  endfunction

  // From Run-Test-Idle, load an instruction, return to Run-Test-Idle
  task automatic load_ir(input logic [3:0] code, output logic [3:0] capt);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    capt[0] = tdo;
    for (int k = 0; k < 4; k++) begin
      step(k == 3, code[k]);
      if (k < 3) capt[k+1] = tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  // From Run-Test-Idle, run one data-register scan and compare tdo
  task automatic scan_dr(input int code, input string req);
    logic sel;
    int   nbits;
    int   bad;
    logic e;
    sel   = (code == 0) || (code == 1);
    nbits = sel ? CHAIN_LEN + BYP_BITS : BYP_BITS;
    bad   = 0;
    step(1, 0); step(0, 0);
    check("R9 capture strobe", 32'(chain_capture), 32'(sel));
    step(0, 0);
    check("R9 shift strobe", 32'(chain_shift), 32'(sel));
    check("R10 oe in shift", 32'(tdo_oe), 32'd1);
    for (int j = 0; j <= nbits; j++) begin
      if (j > 0) step(0, pat_bit(j - 1));
      if (!sel) e = (j == 0) ? 1'b0 : pat_bit(j - 1);
      else      e = (j < CHAIN_LEN) ? cap_bit(j) : pat_bit(j - CHAIN_LEN);
      if (tdo !== e) bad++;
    end
    check(req, 32'(bad), 32'd0);
    step(1, 0); step(1, 0);
    check("R9 update strobe", 32'(chain_update), 32'(sel));
    step(0, 0);
  endtask

  initial begin
    logic [3:0] capt;
    repeat (3) @(negedge tck);
    #1;
    check("R1 reset outputs", {27'd0, ctl()}, 32'd0);
    check("R1 reset oe", {31'd0, tdo_oe}, 32'd0);
    trst_n = 1'b1;
    step(0, 0);
    check("R10 oe idle", {31'd0, tdo_oe}, 32'd0);

    // Sweep all opcodes
    for (int c = 0; c < 16; c++) begin
      load_ir(4'(c), capt);
      check("R3 capture pattern", {28'd0, capt}, 32'd1);
      check("R4 decode", {27'd0, ctl()}, {27'd0, exp_ctl(c)});
      if (c == 0)               scan_dr(c, "R5 extest data path");
      else if (c == 1)          scan_dr(c, "R6 sample data path");
      else if (c == 4 || c == 5) scan_dr(c, "R7 bypass path hiz/clamp");
      else                      scan_dr(c, "R8 bypass delay");
    end

    // R10: tdo holds across rising edge, changes at falling edge
    load_ir(4'hF, capt);
    step(1, 0); step(0, 0); step(0, 0);
    step(0, 1);
    tdi = 1'b0;
    @(posedge tck); #1;
    check("R10 tdo held after rise", {31'd0, tdo}, 32'd1);
    @(negedge tck); #1;
    check("R10 tdo after fall", {31'd0, tdo}, 32'd0);
    step(1, 0); step(1, 0); step(0, 0);

    // R11: Test-Logic-Reset forces bypass decode immediately
    load_ir(4'h0, capt);
    check("R5 extest soft reset", {31'd0, soft_rst}, 32'd1);
    step(1, 0); step(1, 0); step(1, 0);
    check("R11 decode in reset state", {27'd0, ctl()}, 32'd0);
    step(0, 0);
    check("R11 register forced to bypass", {27'd0, ctl()}, 32'd0);

    // R2: five ones from Shift-DR reach Test-Logic-Reset
    load_ir(4'h1, capt);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    check("R2 five ones reset", {27'd0, ctl()}, 32'd0);
    check("R2 oe off after reset", {31'd0, tdo_oe}, 32'd0);
    step(0, 0);

    // R1: asynchronous reset between edges
    load_ir(4'h0, capt);
    check("R1 before async reset", {31'd0, soft_rst}, 32'd1);
    #2 trst_n = 1'b0;
    #1;
    check("R1 async clear", {27'd0, ctl()}, 32'd0);
    trst_n = 1'b1;
    step(0, 0);
    check("R1 bypass after release", {27'd0, ctl()}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(TCK_P * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule